// File: doc/BRIEF.md
# Circular Host Buffer Flow-Control Manager

This block keeps the host-side transfer engine and the flash-side engine in step on two ring buffers of frames held in DRAM. One ring carries data that the flash side reads for the host. The other ring carries host write data that the flash side later programs. The block does not move any data. It only keeps frame-index pointers and decides when the host engine may move on to the next frame.

Each ring has three pointers. The host pointer belongs to the host engine. The firmware pointer advances as firmware issues flash operations. The limit pointer is driven by hardware and advances only when the flash controller reports that a frame has completed. On the read ring, the host pointer may not overtake the limit, so the host never sends a frame that has not been loaded. On the write ring, the host pointer may not lap the limit, so the host never overwrites a frame that has not been programmed. The frame count of each ring is set by an input. Each pointer carries one wrap bit above its index, so a full ring and an empty ring can be told apart.

Firmware can see each limit but cannot write it directly. It can clear a limit to frame 0 or load a limit with a chosen frame index. The block reports the number of pending read frames and the number of free write frames.

Top module: `host_buf_flow_ctrl`

## Requirements
- R1: After reset every pointer is 0 with wrap bit 0. rd_pending_o is 0 and rd_stall_o is 1. wr_free_o equals wr_frames_i and wr_stall_o is 0.
- R2: A pointer advance adds 1 to its index. When the index is the ring's frame count minus 1, an advance sets the index to 0 and inverts the wrap bit. Pointer outputs are {wrap, index}.
- R3: rd_pending_o equals (read limit − host read pointer) using the wrap bit. Its value lies between 0 and rd_frames_i. rd_stall_o is 1 exactly when it is 0. A host_rd_adv_i pulse in a stalled cycle is ignored.
- R4: wr_free_o equals wr_frames_i − (host write pointer − write limit). wr_stall_o is 1 exactly when it is 0. A host_wr_adv_i pulse in a stalled cycle is ignored.
- R5: The read limit advances by one on rd_done_i and for no other strobe. rd_done_i is ignored when rd_pending_o equals rd_frames_i.
- R6: The write limit advances by one on wr_done_i and for no other strobe. wr_done_i is ignored when wr_free_o equals wr_frames_i.
- R7: fw_rd_adv_i and fw_wr_adv_i advance the firmware pointers. They have no effect on the limits, the counts or the stalls.
- R8: lim_clr_i bit 0 sets the write limit index to 0 and bit 1 sets the read limit index to 0. A clear takes priority over a load and over a completion in the same cycle.
- R9: A load sets the limit index to lim_load_id_i. It picks the wrap bit so that rd_pending_o becomes (id − host index) mod rd_frames_i, and wr_free_o becomes wr_frames_i − ((host index − id) mod wr_frames_i). A clear behaves like a load with id 0.
- R10: A host advance and a completion in the same unstalled cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_frames_i | input | CW | Frame count of the read ring (1..MAX_FRAMES) |
| wr_frames_i | input | CW | Frame count of the write ring (1..MAX_FRAMES) |
| host_rd_adv_i | input | 1 | Host engine finished sending one read frame |
| fw_rd_adv_i | input | 1 | Firmware issued one flash read |
| rd_done_i | input | 1 | Flash controller finished loading one read frame |
| host_wr_adv_i | input | 1 | Host engine filled one write frame |
| fw_wr_adv_i | input | 1 | Firmware issued one flash program |
| wr_done_i | input | 1 | Flash controller finished programming one write frame |
| lim_clr_i | input | 2 | Clear a limit to frame 0: bit 0 write, bit 1 read |
| rd_lim_load_i | input | 1 | Load the read limit with lim_load_id_i |
| wr_lim_load_i | input | 1 | Load the write limit with lim_load_id_i |
| lim_load_id_i | input | IW | Frame index used by a load |
| host_rd_ptr_o | output | IW+1 | Host read pointer {wrap, index} |
| fw_rd_ptr_o | output | IW+1 | Firmware read pointer |
| rd_lim_o | output | IW+1 | Read limit |
| host_wr_ptr_o | output | IW+1 | Host write pointer |
| fw_wr_ptr_o | output | IW+1 | Firmware write pointer |
| wr_lim_o | output | IW+1 | Write limit |
| rd_stall_o | output | 1 | Host read engine must hold |
| wr_stall_o | output | 1 | Host write engine must hold |
| rd_pending_o | output | CW | Frames loaded but not yet sent to the host |
| wr_free_o | output | CW | Write frames the host may still fill |

## Verification
Every state bit is a registered pointer, so a wrong pointer shows at the ports one cycle after the strobe that caused it. It appears on the pointer outputs and on the pending or free count. A wrap bit that is not inverted at the last frame keeps the index right but makes the count wrong by a whole ring. The tests therefore run each ring through more than one lap and check both counts and both stalls. A stall that is missing or comes too early shows up as a changed host pointer in the next cycle. A wrong load wrap shows up directly in the count after a clear or a load.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;
  typedef enum logic {
    RING_READ  = 1'b0,
    RING_WRITE = 1'b1
  } ring_kind_e;
endpackage

// File: rtl/hbuf_ptr.sv
module hbuf_ptr #(
  parameter int IW = 4,
  parameter int FW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] frames_i,
  input  logic          adv_i,
  input  logic          load_i,
  input  logic [IW-1:0] load_idx_i,
  input  logic          load_wrap_i,
  output logic [IW-1:0] idx_o,
  output logic          wrap_o
);
  logic last;
  assign last = ({1'b0, idx_o} == FW'(frames_i - FW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o  <= '0;
      wrap_o <= 1'b0;
    end else if (load_i) begin
      idx_o  <= load_idx_i;
      wrap_o <= load_wrap_i;
    end else if (adv_i) begin
      if (last) begin
        idx_o  <= '0;
        wrap_o <= ~wrap_o;
      end else begin
        idx_o  <= idx_o + IW'(1);
      end
    end
  end

  // R2: index returns to zero after the last frame, wrap bit flips
  a_r2_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && last) |=> (idx_o == '0 && wrap_o != $past(wrap_o)));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !last) |=> (idx_o == $past(idx_o) + IW'(1)));
endmodule

// File: rtl/hbuf_ring.sv
module hbuf_ring
  import hbuf_pkg::*;
#(
  parameter ring_kind_e KIND = RING_READ,
  parameter int IW = 4,
  parameter int FW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] frames_i,
  input  logic          host_adv_i,
  input  logic          fw_adv_i,
  input  logic          done_i,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [IW-1:0] load_idx_i,
  output logic [IW:0]   host_ptr_o,
  output logic [IW:0]   fw_ptr_o,
  output logic [IW:0]   lim_ptr_o,
  output logic          stall_o,
  output logic [FW-1:0] count_o
);
  logic [IW-1:0] host_idx, fw_idx, lim_idx, lead_idx, trail_idx, lim_ld_idx;
  logic          host_wrap, fw_wrap, lim_wrap, lead_wrap, trail_wrap, lim_ld_wrap;
  logic [FW-1:0] occ;
  logic          lim_block, host_go, lim_go, lim_ld;

  // occupancy = lead - trail, ring distance resolved by the wrap bit
  assign occ = (lead_wrap == trail_wrap) ? FW'(lead_idx) - FW'(trail_idx)
                                         : FW'(lead_idx) + frames_i - FW'(trail_idx);

  assign lim_ld     = clr_i | load_i;
  assign lim_ld_idx = clr_i ? '0 : load_idx_i;

  generate
    if (KIND == RING_READ) begin : g_read
      // limit leads, host trails; empty means nothing to send
      assign lead_idx    = lim_idx;
      assign lead_wrap   = lim_wrap;
      assign trail_idx   = host_idx;
      assign trail_wrap  = host_wrap;
      assign stall_o     = (occ == '0);
      assign lim_block   = (occ == frames_i);
      assign count_o     = occ;
      assign lim_ld_wrap = (lim_ld_idx >= host_idx) ? host_wrap : ~host_wrap;
    end else begin : g_write
      // host leads, limit trails; full means no free frame
      assign lead_idx    = host_idx;
      assign lead_wrap   = host_wrap;
      assign trail_idx   = lim_idx;
      assign trail_wrap  = lim_wrap;
      assign stall_o     = (occ == frames_i);
      assign lim_block   = (occ == '0);
      assign count_o     = frames_i - occ;
      assign lim_ld_wrap = (host_idx >= lim_ld_idx) ? host_wrap : ~host_wrap;
    end
  endgenerate

  assign host_go = host_adv_i & ~stall_o;
  assign lim_go  = done_i & ~lim_block;

  hbuf_ptr #(.IW(IW), .FW(FW)) u_host (
    .clk_i, .rst_ni, .frames_i, .adv_i(host_go), .load_i(1'b0),
    .load_idx_i('0), .load_wrap_i(1'b0), .idx_o(host_idx), .wrap_o(host_wrap)
  );
  hbuf_ptr #(.IW(IW), .FW(FW)) u_fw (
    .clk_i, .rst_ni, .frames_i, .adv_i(fw_adv_i), .load_i(1'b0),
    .load_idx_i('0), .load_wrap_i(1'b0), .idx_o(fw_idx), .wrap_o(fw_wrap)
  );
  hbuf_ptr #(.IW(IW), .FW(FW)) u_lim (
    .clk_i, .rst_ni, .frames_i, .adv_i(lim_go), .load_i(lim_ld),
    .load_idx_i(lim_ld_idx), .load_wrap_i(lim_ld_wrap), .idx_o(lim_idx), .wrap_o(lim_wrap)
  );

  assign host_ptr_o = {host_wrap, host_idx};
  assign fw_ptr_o   = {fw_wrap, fw_idx};
  assign lim_ptr_o  = {lim_wrap, lim_idx};

  // R3 (read ring) / R4 (write ring): stalled host strobe leaves the pointer alone
  a_r3_r4_host_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && host_adv_i) |=> $stable(host_ptr_o));
  // R5 / R6: the limit moves only on a completion, clear or load
  a_r5_r6_lim_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !clr_i && !load_i) |=> $stable(lim_ptr_o));
  // R5 / R6: a blocked completion is dropped
  a_r5_r6_lim_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_block && !clr_i && !load_i) |=> $stable(lim_ptr_o));
  // R8: clear sends the limit index to frame 0
  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (lim_ptr_o[IW-1:0] == '0));
  // R3 / R4: count stays inside the ring
  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= frames_i);
  // R7: firmware strobe never touches the limit
  a_r7_fw_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fw_adv_i && !done_i && !clr_i && !load_i) |=> $stable(lim_ptr_o));
endmodule

// File: rtl/host_buf_flow_ctrl.sv
module host_buf_flow_ctrl
  import hbuf_pkg::*;
#(
  parameter int MAX_FRAMES = 16,
  localparam int IW = $clog2(MAX_FRAMES),
  localparam int CW = $clog2(MAX_FRAMES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] rd_frames_i,
  input  logic [CW-1:0] wr_frames_i,
  input  logic          host_rd_adv_i,
  input  logic          fw_rd_adv_i,
  input  logic          rd_done_i,
  input  logic          host_wr_adv_i,
  input  logic          fw_wr_adv_i,
  input  logic          wr_done_i,
  input  logic [1:0]    lim_clr_i,
  input  logic          rd_lim_load_i,
  input  logic          wr_lim_load_i,
  input  logic [IW-1:0] lim_load_id_i,
  output logic [IW:0]   host_rd_ptr_o,
  output logic [IW:0]   fw_rd_ptr_o,
  output logic [IW:0]   rd_lim_o,
  output logic [IW:0]   host_wr_ptr_o,
  output logic [IW:0]   fw_wr_ptr_o,
  output logic [IW:0]   wr_lim_o,
  output logic          rd_stall_o,
  output logic          wr_stall_o,
  output logic [CW-1:0] rd_pending_o,
  output logic [CW-1:0] wr_free_o
);
  hbuf_ring #(.KIND(RING_READ), .IW(IW), .FW(CW)) u_rd_ring (
    .clk_i, .rst_ni,
    .frames_i   (rd_frames_i),
    .host_adv_i (host_rd_adv_i),
    .fw_adv_i   (fw_rd_adv_i),
    .done_i     (rd_done_i),
    .clr_i      (lim_clr_i[1]),
    .load_i     (rd_lim_load_i),
    .load_idx_i (lim_load_id_i),
    .host_ptr_o (host_rd_ptr_o),
    .fw_ptr_o   (fw_rd_ptr_o),
    .lim_ptr_o  (rd_lim_o),
    .stall_o    (rd_stall_o),
    .count_o    (rd_pending_o)
  );

  hbuf_ring #(.KIND(RING_WRITE), .IW(IW), .FW(CW)) u_wr_ring (
    .clk_i, .rst_ni,
    .frames_i   (wr_frames_i),
    .host_adv_i (host_wr_adv_i),
    .fw_adv_i   (fw_wr_adv_i),
    .done_i     (wr_done_i),
    .clr_i      (lim_clr_i[0]),
    .load_i     (wr_lim_load_i),
    .load_idx_i (lim_load_id_i),
    .host_ptr_o (host_wr_ptr_o),
    .fw_ptr_o   (fw_wr_ptr_o),
    .lim_ptr_o  (wr_lim_o),
    .stall_o    (wr_stall_o),
    .count_o    (wr_free_o)
  );

  // R3 / R4: stall outputs agree with the reported counts
  a_r3_rd_stall_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stall_o == (rd_pending_o == '0));
  a_r4_wr_stall_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stall_o == (wr_free_o == '0));
endmodule

// File: tb/tb_host_buf_flow_ctrl.sv
module tb_host_buf_flow_ctrl;
  localparam int MAXF = 16;
  localparam int IW = $clog2(MAXF);
  localparam int CW = $clog2(MAXF + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [CW-1:0] rd_frames = CW'(5), wr_frames = CW'(4);
  logic host_rd_adv = 0, fw_rd_adv = 0, rd_done = 0;
  logic host_wr_adv = 0, fw_wr_adv = 0, wr_done = 0;
  logic [1:0] lim_clr = '0;
  logic rd_lim_load = 0, wr_lim_load = 0;
  logic [IW-1:0] lim_load_id = '0;
  logic [IW:0] host_rd_ptr, fw_rd_ptr, rd_lim, host_wr_ptr, fw_wr_ptr, wr_lim;
  logic rd_stall, wr_stall;
  logic [CW-1:0] rd_pending, wr_free;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  host_buf_flow_ctrl #(.MAX_FRAMES(MAXF)) dut (
    .clk_i(clk), .rst_ni,
    .rd_frames_i(rd_frames), .wr_frames_i(wr_frames),
    .host_rd_adv_i(host_rd_adv), .fw_rd_adv_i(fw_rd_adv), .rd_done_i(rd_done),
    .host_wr_adv_i(host_wr_adv), .fw_wr_adv_i(fw_wr_adv), .wr_done_i(wr_done),
    .lim_clr_i(lim_clr), .rd_lim_load_i(rd_lim_load), .wr_lim_load_i(wr_lim_load),
    .lim_load_id_i(lim_load_id),
    .host_rd_ptr_o(host_rd_ptr), .fw_rd_ptr_o(fw_rd_ptr), .rd_lim_o(rd_lim),
    .host_wr_ptr_o(host_wr_ptr), .fw_wr_ptr_o(fw_wr_ptr), .wr_lim_o(wr_lim),
    .rd_stall_o(rd_stall), .wr_stall_o(wr_stall),
    .rd_pending_o(rd_pending), .wr_free_o(wr_free)
  );

  typedef struct packed {
    logic hr, rdn, hw, wdn;
    logic [4:0] rp;
    logic rs;
    logic [4:0] wf;
    logic ws;
  } vec_t;

  // read ring 5 frames, write ring 4 frames; expected values after each cycle
  localparam vec_t VEC [0:11] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, 5'd0, 1'b1, 5'd3, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 5'd1, 1'b0, 5'd2, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 5'd1, 1'b0, 5'd1, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 5'd2, 1'b0, 5'd0, 1'b1},
    '{1'b1, 1'b0, 1'b1, 1'b0, 5'd1, 1'b0, 5'd0, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b1, 5'd2, 1'b0, 5'd1, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b1, 5'd3, 1'b0, 5'd1, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 5'd4, 1'b0, 5'd2, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 5'd5, 1'b0, 5'd3, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 5'd5, 1'b0, 5'd4, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 5'd4, 1'b0, 5'd4, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 5'd3, 1'b0, 5'd4, 1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    host_rd_adv = 0; fw_rd_adv = 0; rd_done = 0;
    host_wr_adv = 0; fw_wr_adv = 0; wr_done = 0;
    lim_clr = '0; rd_lim_load = 0; wr_lim_load = 0; lim_load_id = '0;
  endtask

  // inputs set at negedge, outputs sampled 1 ns after the next posedge
  task automatic tick();
    @(posedge clk);
    #1;
    clear_inputs();
  endtask

  task automatic check_reset_state();
    chk("R1", "host_rd_ptr", host_rd_ptr, 0);
    chk("R1", "rd_lim", rd_lim, 0);
    chk("R1", "fw_wr_ptr", fw_wr_ptr, 0);
    chk("R1", "wr_lim", wr_lim, 0);
    chk("R1", "rd_pending", rd_pending, 0);
    chk("R1", "rd_stall", rd_stall, 1);
    chk("R1", "wr_free", wr_free, 4);
    chk("R1", "wr_stall", wr_stall, 0);
  endtask

  initial begin
    #(5ns * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_reset_state();

    // R3 R4 R5 R6 R10: table of strobes and expected counts
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      host_rd_adv = VEC[i].hr; rd_done = VEC[i].rdn;
      host_wr_adv = VEC[i].hw; wr_done = VEC[i].wdn;
      tick();
      chk("R3", $sformatf("rd_pending v%0d", i), rd_pending, VEC[i].rp);
      chk("R3", $sformatf("rd_stall v%0d", i), rd_stall, VEC[i].rs);
      chk("R4", $sformatf("wr_free v%0d", i), wr_free, VEC[i].wf);
      chk("R4", $sformatf("wr_stall v%0d", i), wr_stall, VEC[i].ws);
    end

    // R2: pointers after more than one lap
    chk("R2", "host_rd_ptr", host_rd_ptr, 5'h04);
    chk("R2", "rd_lim", rd_lim, 5'h12);
    chk("R2", "host_wr_ptr", host_wr_ptr, 5'h11);
    chk("R2", "wr_lim", wr_lim, 5'h11);

    // R7: firmware strobes move only their own pointers
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      fw_rd_adv = 1;
      fw_wr_adv = (i < 3);
      tick();
    end
    chk("R7", "fw_rd_ptr", fw_rd_ptr, 5'h11);
    chk("R7", "fw_wr_ptr", fw_wr_ptr, 5'h03);
    chk("R7", "rd_lim", rd_lim, 5'h12);
    chk("R7", "rd_pending", rd_pending, 3);
    chk("R7", "wr_free", wr_free, 4);

    // R8: clear beats completion and load
    @(negedge clk);
    lim_clr = 2'b11; rd_done = 1; wr_done = 1; wr_lim_load = 1; lim_load_id = 2;
    tick();
    chk("R8", "rd_lim", rd_lim, 5'h10);
    chk("R8", "wr_lim", wr_lim, 5'h10);
    chk("R8", "rd_pending", rd_pending, 1);
    chk("R8", "wr_free", wr_free, 3);

    // R9: loads with ids on both sides of the host pointer
    @(negedge clk);
    rd_lim_load = 1; lim_load_id = 3;
    tick();
    chk("R9", "rd_lim", rd_lim, 5'h13);
    chk("R9", "rd_pending", rd_pending, 4);
    @(negedge clk);
    wr_lim_load = 1; lim_load_id = 2;
    tick();
    chk("R9", "wr_lim", wr_lim, 5'h02);
    chk("R9", "wr_free", wr_free, 1);
    @(negedge clk);
    rd_lim_load = 1; lim_load_id = 4;
    tick();
    chk("R9", "rd_pending", rd_pending, 0);
    chk("R9", "rd_stall", rd_stall, 1);

    // R1: reset in mid-run returns to the initial state
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_reset_state();
    chk("R1", "fw_rd_ptr", fw_rd_ptr, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule